// File: doc/BRIEF.md
# Breadth-First Tree-Search Detector Layer Stage

This block is one layer of a pipelined breadth-first tree-search detector for a multi-antenna receiver that works on the real-valued form of the channel. Each real dimension carries one of four amplitude levels. The stage receives K surviving branches. Each branch brings an accumulated partial Euclidean distance (PED), the symbol path chosen so far, and its interference-cancelled target value for this layer. The stage also receives the four products of the layer's diagonal channel coefficient with the four amplitude levels. These products come from a per-channel table held upstream.

Every branch is grown into its four children. Each child's distance grows by the squared error between the target and that child's product. Only the cheapest child of each branch survives, and it goes to the next stage with its index appended to the path. No radius test is applied, so every branch always yields one survivor. There are two schedules. In the top-layer schedule all branches are expanded in the same cycle. In the lower-layer schedule one branch, which means four children, is expanded per cycle. In both schedules a two-step minimum search follows.

Top module: `bfs_layer_stage`

## Requirements
- R1: Child j of a branch has distance parent + (target − prod_j)², where target and prod_j are signed 16-bit values. prod_j is taken from in_prod bits [16j+15:16j], and index j = 0, 1, 2, 3 stands for the levels −3, −1, +1, +3.
- R2: For each branch the reported distance is the smallest child distance. The reported path is the input path shifted left by two bits, with the winning index j in bits [1:0].
- R3: When two children of a branch have equal distances, the child with the lower index wins.
- R4: A child distance saturates at 65535 and does not wrap.
- R5: With in_root high at acceptance, out_valid rises on the third rising edge after the accepting edge.
- R6: With in_root low at acceptance, out_valid rises on the (K+2)-th rising edge after the accepting edge. That is the sixth edge for K = 4.
- R7: in_valid is ignored while a symbol vector is in flight. The cycle in which out_valid is high is idle, so in_valid in that cycle is accepted.
- R8: During reset, out_valid, out_ped and out_path are zero.
- R9: Every branch produces a result, and the result's distance is never below the parent's distance.
- R10: out_valid is high for exactly one cycle per accepted vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Presents a new set of K branches |
| in_root | input | 1 | 1: expand all branches in one cycle; 0: one branch per cycle |
| in_ped | input | K*16 | Parent distances, branch k at [16k+15:16k] |
| in_tgt | input | K*16 | Signed interference-cancelled targets per branch |
| in_path | input | K*8 | Symbol paths so far per branch |
| in_prod | input | 64 | Signed products of the diagonal coefficient with levels −3, −1, +1, +3 |
| out_valid | output | 1 | One-cycle strobe: all K results updated |
| out_ped | output | K*16 | Surviving distance per branch |
| out_path | output | K*8 | Surviving path per branch |

## Verification
The stage is idle during its own output cycle, so the strobe of one vector can fall in the same cycle as the acceptance of the next. The bench provokes this by raising in_valid in the cycle where out_valid is seen. It then checks that the previous results are intact and that the new vector's strobe follows at exactly the top-layer latency. Before that, a second in_valid is raised in the middle of a lower-layer run. That vector must leave no trace: there must be no early strobe and no change to the result.

// File: rtl/bfs_layer_pkg.sv
package bfs_layer_pkg;
  // Four amplitude levels per real dimension, so four children per branch.
  localparam int unsigned CHILDREN = 4;
  localparam int unsigned IDX_W    = 2;
  typedef logic [IDX_W-1:0] child_idx_t;
endpackage

// File: rtl/bfs_rst_sync.sv
module bfs_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= 2'b00;
    else              sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/bfs_child_metric.sv
module bfs_child_metric
  import bfs_layer_pkg::*;
#(
  parameter int unsigned PED_W = 16,
  parameter int unsigned VAL_W = 16
) (
  input  logic [PED_W-1:0]          parent_ped,
  input  logic [VAL_W-1:0]          target,
  input  logic [CHILDREN*VAL_W-1:0] prods,
  output logic [CHILDREN*PED_W-1:0] child_ped
);
  localparam int unsigned ERR_W = VAL_W + 1;
  localparam int unsigned SQ_W  = 2 * ERR_W;
  localparam int unsigned SUM_W = SQ_W + 1;

  for (genvar j = 0; j < CHILDREN; j++) begin : g_child
    logic [VAL_W-1:0]        prod_j;
    logic signed [SQ_W-1:0]  err_x;
    logic [SQ_W-1:0]         sq;
    logic [SUM_W-1:0]        sum;

    assign prod_j = prods[j*VAL_W +: VAL_W];

    always_comb begin
      // Difference in ERR_W bits, sign-extended to SQ_W so the square is exact.
      err_x = $signed({{(SQ_W-VAL_W){target[VAL_W-1]}}, target})
            - $signed({{(SQ_W-VAL_W){prod_j[VAL_W-1]}}, prod_j});
      sq    = $unsigned(err_x * err_x);
      sum   = {{(SUM_W-PED_W){1'b0}}, parent_ped} + {1'b0, sq};
      child_ped[j*PED_W +: PED_W] = (|sum[SUM_W-1:PED_W]) ? {PED_W{1'b1}}
                                                            : sum[PED_W-1:0];
    end
  end
endmodule

// File: rtl/bfs_min_select.sv
module bfs_min_select
  import bfs_layer_pkg::*;
#(
  parameter int unsigned PED_W  = 16,
  parameter int unsigned PATH_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [CHILDREN*PED_W-1:0] child_ped,
  input  logic [PATH_W-1:0]         in_path,
  output logic [PED_W-1:0]          win_ped,
  output logic [PATH_W-1:0]         win_path
);
  // First step: two pairwise comparators in parallel.
  logic [PED_W-1:0]  c0, c1, c2, c3;
  logic [PED_W-1:0]  lo_ped_d, hi_ped_d, lo_ped_q, hi_ped_q;
  child_idx_t        lo_idx_d, hi_idx_d, lo_idx_q, hi_idx_q;
  logic [PATH_W-1:0] mid_path_q;
  logic              mid_v_q;
  // Second step: one comparator, then the path append.
  logic [PED_W-1:0]  res_ped_d;
  logic [PATH_W-1:0] res_path_d;
  child_idx_t        res_idx;

  assign c0 = child_ped[0*PED_W +: PED_W];
  assign c1 = child_ped[1*PED_W +: PED_W];
  assign c2 = child_ped[2*PED_W +: PED_W];
  assign c3 = child_ped[3*PED_W +: PED_W];

  always_comb begin
    // Strict less-than keeps the lower index on a tie.
    if (c1 < c0) begin lo_ped_d = c1; lo_idx_d = 2'd1; end
    else         begin lo_ped_d = c0; lo_idx_d = 2'd0; end
    if (c3 < c2) begin hi_ped_d = c3; hi_idx_d = 2'd3; end
    else         begin hi_ped_d = c2; hi_idx_d = 2'd2; end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mid_v_q <= 1'b0;
    else        mid_v_q <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      lo_ped_q   <= lo_ped_d;
      lo_idx_q   <= lo_idx_d;
      hi_ped_q   <= hi_ped_d;
      hi_idx_q   <= hi_idx_d;
      mid_path_q <= in_path;
    end
  end

  always_comb begin
    if (hi_ped_q < lo_ped_q) begin res_ped_d = hi_ped_q; res_idx = hi_idx_q; end
    else                     begin res_ped_d = lo_ped_q; res_idx = lo_idx_q; end
    res_path_d = {mid_path_q[PATH_W-IDX_W-1:0], res_idx};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_ped  <= '0;
      win_path <= '0;
    end else if (mid_v_q) begin
      win_ped  <= res_ped_d;
      win_path <= res_path_d;
    end
  end
endmodule

// File: rtl/bfs_layer_stage.sv
module bfs_layer_stage
  import bfs_layer_pkg::*;
#(
  parameter int unsigned K      = 4,
  parameter int unsigned PED_W  = 16,
  parameter int unsigned VAL_W  = 16,
  parameter int unsigned PATH_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic                      in_root,
  input  logic [K*PED_W-1:0]        in_ped,
  input  logic [K*VAL_W-1:0]        in_tgt,
  input  logic [K*PATH_W-1:0]       in_path,
  input  logic [CHILDREN*VAL_W-1:0] in_prod,
  output logic                      out_valid,
  output logic [K*PED_W-1:0]        out_ped,
  output logic [K*PATH_W-1:0]       out_path
);
  localparam int unsigned STEP_W = $clog2(K + 1);
  localparam int unsigned FIN_W  = 3;  // fire -> metric -> pair -> result

  logic                      rst_sync_n;
  logic                      accept;
  logic                      busy_q, busy_d;
  logic [STEP_W-1:0]         step_q, step_d;
  logic                      root_q;
  logic [K*PED_W-1:0]        cap_ped_q;
  logic [K*VAL_W-1:0]        cap_tgt_q;
  logic [K*PATH_W-1:0]       cap_path_q;
  logic [CHILDREN*VAL_W-1:0] cap_prod_q;
  logic [K-1:0]              lane_fire;
  logic [FIN_W-1:0]          fin_q;

  bfs_rst_sync u_rst (.clk(clk), .rst_n_async(rst_n), .rst_n_sync(rst_sync_n));

  assign accept = in_valid && !busy_q;

  // Sequencer next state.
  always_comb begin
    busy_d = busy_q;
    step_d = step_q;
    if (accept) begin
      busy_d = 1'b1;
      step_d = '0;
    end else begin
      if (busy_q && fin_q[FIN_W-2]) busy_d = 1'b0;
      if (busy_q && step_q != STEP_W'(K)) step_d = step_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync_or_async) begin
    if (!rst_n_sync_or_async) begin
      busy_q <= 1'b0;
      step_q <= '0;
      fin_q  <= '0;
    end else begin
      busy_q <= busy_d;
      step_q <= step_d;
      fin_q  <= {fin_q[FIN_W-2:0], lane_fire[K-1]};
    end
  end

  logic rst_n_sync_or_async;
  assign rst_n_sync_or_async = rst_sync_n;

  // Input capture, datapath only: no reset needed.
  always_ff @(posedge clk) begin
    if (accept) begin
      root_q     <= in_root;
      cap_ped_q  <= in_ped;
      cap_tgt_q  <= in_tgt;
      cap_path_q <= in_path;
      cap_prod_q <= in_prod;
    end
  end

  assign out_valid = fin_q[FIN_W-1];

  for (genvar k = 0; k < K; k++) begin : g_lane
    logic [CHILDREN*PED_W-1:0] kid_ped;
    logic [CHILDREN*PED_W-1:0] s0_ped_q;
    logic [PATH_W-1:0]         s0_path_q;
    logic                      s0_v_q;

    assign lane_fire[k] = busy_q && (root_q ? (step_q == '0)
                                            : (step_q == STEP_W'(k)));

    bfs_child_metric #(.PED_W(PED_W), .VAL_W(VAL_W)) u_metric (
      .parent_ped (cap_ped_q[k*PED_W +: PED_W]),
      .target     (cap_tgt_q[k*VAL_W +: VAL_W]),
      .prods      (cap_prod_q),
      .child_ped  (kid_ped)
    );

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) s0_v_q <= 1'b0;
      else             s0_v_q <= lane_fire[k];
    end

    always_ff @(posedge clk) begin
      if (lane_fire[k]) begin
        s0_ped_q  <= kid_ped;
        s0_path_q <= cap_path_q[k*PATH_W +: PATH_W];
      end
    end

    bfs_min_select #(.PED_W(PED_W), .PATH_W(PATH_W)) u_sel (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .in_valid  (s0_v_q),
      .child_ped (s0_ped_q),
      .in_path   (s0_path_q),
      .win_ped   (out_ped[k*PED_W +: PED_W]),
      .win_path  (out_path[k*PATH_W +: PATH_W])
    );
  end
endmodule

// File: rtl/bfs_layer_stage_chk.sv
module bfs_layer_stage_chk #(
  parameter int unsigned K      = 4,
  parameter int unsigned PED_W  = 16,
  parameter int unsigned PATH_W = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  in_root,
  input logic [K*PED_W-1:0]    in_ped,
  input logic [K*PATH_W-1:0]   in_path,
  input logic                  busy,
  input logic                  out_valid,
  input logic [K*PED_W-1:0]    out_ped,
  input logic [K*PATH_W-1:0]   out_path
);
  logic [7:0]          cnt_q;
  logic                root_q;
  logic [K*PED_W-1:0]  ped_q;
  logic [K*PATH_W-1:0] path_q;
  logic                acc;

  assign acc = in_valid && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      root_q <= 1'b0;
      ped_q  <= '0;
      path_q <= '0;
    end else if (acc) begin
      cnt_q  <= 8'd1;
      root_q <= in_root;
      ped_q  <= in_ped;
      path_q <= in_path;
    end else if (cnt_q != 8'd0 && cnt_q != 8'hFF) begin
      cnt_q  <= cnt_q + 8'd1;
    end
  end

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  a_r5_root_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && root_q) |-> (cnt_q == 8'd4));

  a_r6_lower_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !root_q) |-> (cnt_q == 8'(K + 3)));

  a_r7_no_orphan_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (cnt_q != 8'd0));

  for (genvar k = 0; k < K; k++) begin : g_br
    a_r9_ped_floor: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_ped[k*PED_W +: PED_W] >= ped_q[k*PED_W +: PED_W]));

    a_r2_path_shift: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_path[k*PATH_W+2 +: PATH_W-2] == path_q[k*PATH_W +: PATH_W-2]));
  end
endmodule

bind bfs_layer_stage bfs_layer_stage_chk #(.K(K), .PED_W(PED_W), .PATH_W(PATH_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .in_root   (in_root),
  .in_ped    (in_ped),
  .in_path   (in_path),
  .busy      (busy_q),
  .out_valid (out_valid),
  .out_ped   (out_ped),
  .out_path  (out_path)
);

// File: tb/bfs_layer_stage_tb.sv
module bfs_layer_stage_tb;
  localparam int K = 4;

  typedef struct packed {
    logic        root;
    logic [63:0] ped;
    logic [63:0] tgt;
    logic [31:0] path;
    logic [63:0] prod;
  } vec_t;

  localparam logic [63:0] P2 = {16'h0006, 16'h0002, 16'hFFFE, 16'hFFFA};
  localparam logic [63:0] P5 = {16'h000F, 16'h0005, 16'hFFFB, 16'hFFF1};
  localparam logic [63:0] P0 = 64'h0;

  localparam vec_t VECS [6] = '{
    '{root:1'b1, ped:{16'd100, 16'd10, 16'd5, 16'd0},
      tgt:{16'd100, 16'd0, 16'hFFFB, 16'd3}, path:{8'h3C, 8'h12, 8'hA5, 8'h01}, prod:P2},
    '{root:1'b0, ped:{16'd7, 16'd1000, 16'd65000, 16'd12},
      tgt:{16'hFFF7, 16'd4, 16'd300, 16'd16}, path:{8'h00, 8'hFF, 8'h81, 8'h5A}, prod:P5},
    '{root:1'b1, ped:{16'd0, 16'd0, 16'd0, 16'd0},
      tgt:{16'h7FFF, 16'h8000, 16'd10, 16'hFFF6}, path:{8'h11, 8'h22, 8'h33, 8'h44}, prod:P5},
    '{root:1'b0, ped:{16'd1, 16'd2, 16'd3, 16'd4},
      tgt:{16'd1, 16'hFFFF, 16'd4, 16'hFFFC}, path:{8'hC3, 8'h0F, 8'hF0, 8'h69}, prod:P2},
    '{root:1'b0, ped:{16'd9, 16'd300, 16'd0, 16'd77},
      tgt:{16'd5, 16'hFF00, 16'd0, 16'd1234}, path:{8'h01, 8'h02, 8'h03, 8'h04}, prod:P0},
    '{root:1'b1, ped:{16'd65534, 16'd65535, 16'd0, 16'd40},
      tgt:{16'd2, 16'hFFFA, 16'd5, 16'd0}, path:{8'hAA, 8'h55, 8'hE7, 8'h18}, prod:P2}
  };

  logic            clk, rst_n, in_valid, in_root;
  logic [K*16-1:0] in_ped, in_tgt;
  logic [K*8-1:0]  in_path;
  logic [63:0]     in_prod;
  logic            out_valid;
  logic [K*16-1:0] out_ped;
  logic [K*8-1:0]  out_path;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 0;

  bfs_layer_stage #(.K(K)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_root(in_root),
    .in_ped(in_ped), .in_tgt(in_tgt), .in_path(in_path), .in_prod(in_prod),
    .out_valid(out_valid), .out_ped(out_ped), .out_path(out_path)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL R10 watchdog: cycles=%0d expected=<20000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk_eq(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Independent reference: exhaustive over the four levels, saturating, low index on ties.
  function automatic logic [17:0] model_branch(logic [15:0] ped, logic [15:0] tgt, logic [63:0] prod);
    longint best = 1000000;
    int bi = 0;
    for (int j = 0; j < 4; j++) begin
      longint e = longint'($signed(tgt)) - longint'($signed(prod[16*j +: 16]));
      longint s = longint'(ped) + e * e;
      if (s > 65535) s = 65535;
      if (s < best) begin best = s; bi = j; end
    end
    return {bi[1:0], best[15:0]};
  endfunction

  task automatic apply(vec_t v);
    in_root = v.root; in_ped = v.ped; in_tgt = v.tgt; in_path = v.path; in_prod = v.prod;
  endtask

  // Drive at a falling edge, accepted at the next rising edge; returns at the falling edge after it.
  task automatic launch(vec_t v);
    @(negedge clk);
    apply(v);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic await_out(inout int cyc);
    while (!out_valid && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic check_results(vec_t v);
    for (int k = 0; k < K; k++) begin
      logic [17:0] m;
      m = model_branch(v.ped[16*k +: 16], v.tgt[16*k +: 16], v.prod);
      chk_eq("R1", $sformatf("ped branch %0d", k), out_ped[16*k +: 16], m[15:0]);
      chk_eq("R2", $sformatf("path branch %0d", k), out_path[8*k +: 8],
             {v.path[8*k +: 6], m[17:16]});
      n_chk++;
      if (out_ped[16*k +: 16] < v.ped[16*k +: 16]) begin
        n_fail++;
        $display("FAIL R9 floor branch %0d: actual=%0d expected>=%0d", k,
                 out_ped[16*k +: 16], v.ped[16*k +: 16]);
      end
    end
  endtask

  initial begin
    vec_t tv;
    int cyc;
    rst_n = 1'b0; in_valid = 1'b0; in_root = 1'b0;
    in_ped = '0; in_tgt = '0; in_path = '0; in_prod = '0;
    repeat (3) @(negedge clk);
    chk_eq("R8", "out_valid in reset", out_valid, 0);
    chk_eq("R8", "out_ped in reset", out_ped, 0);
    chk_eq("R8", "out_path in reset", out_path, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_eq("R8", "out_valid after release", out_valid, 0);

    // Table walk: R1, R2, R9 per branch; R5 / R6 latency; R10 pulse width.
    for (int i = 0; i < 6; i++) begin
      launch(VECS[i]);
      cyc = 1;
      await_out(cyc);
      if (VECS[i].root) chk_eq("R5", $sformatf("root latency vec %0d", i), cyc, 4);
      else              chk_eq("R6", $sformatf("lower latency vec %0d", i), cyc, K + 3);
      check_results(VECS[i]);
      @(negedge clk);
      chk_eq("R10", $sformatf("strobe width vec %0d", i), out_valid, 0);
    end

    // R3: target 0 with products -6,-2,+2,+6: children 1 and 2 tie, index 1 wins.
    tv = '{root:1'b1, ped:{16'd50, 16'd0, 16'd7, 16'd1}, tgt:64'h0,
           path:{8'h00, 8'h00, 8'h00, 8'h00}, prod:P2};
    launch(tv);
    cyc = 1;
    await_out(cyc);
    chk_eq("R3", "tie ped b0", out_ped[15:0], 5);
    chk_eq("R3", "tie idx b0", out_path[1:0], 1);
    chk_eq("R3", "tie idx b3", out_path[25:24], 1);

    // R4: saturation edges against hand-worked values.
    tv = '{root:1'b0, ped:{16'd65530, 16'd65000, 16'd65535, 16'd65534},
           tgt:{16'd3, 16'd0, 16'd2, 16'd1}, path:32'h0, prod:P2};
    launch(tv);
    cyc = 1;
    await_out(cyc);
    chk_eq("R4", "all children saturated b0", out_ped[15:0], 65535);
    chk_eq("R4", "saturated tie idx b0", out_path[1:0], 0);
    chk_eq("R4", "exact max ties saturated b1", out_ped[31:16], 65535);
    chk_eq("R4", "near max b2", out_ped[47:32], 65004);
    chk_eq("R4", "near max idx b2", out_path[17:16], 1);
    chk_eq("R4", "near max b3", out_ped[63:48], 65531);
    chk_eq("R4", "near max idx b3", out_path[25:24], 2);

    // R7: in_valid mid-run is dropped; in_valid during the strobe cycle is taken.
    launch(VECS[3]);
    cyc = 1;
    @(negedge clk); cyc++;
    @(negedge clk); cyc++;
    apply(VECS[0]);
    in_valid = 1'b1;
    @(negedge clk); cyc++;
    in_valid = 1'b0;
    await_out(cyc);
    chk_eq("R7", "busy vector dropped, latency", cyc, K + 3);
    check_results(VECS[3]);
    apply(VECS[2]);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk_eq("R10", "strobe low after overlap", out_valid, 0);
    cyc = 1;
    await_out(cyc);
    chk_eq("R7", "accept in strobe cycle, latency", cyc, 4);
    check_results(VECS[2]);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule